// File: doc/BRIEF.md
# Local/Remote Register Window Redirector

This block sits in front of the global control register space of a multi-core cluster. It decodes a 32 KB register address space into four 8 KB windows: global, core-local, core-remote and debug. A read or write in the core-local window lands on the requesting core's own per-core registers. A read or write in the core-remote window is steered by a pointer register that belongs to the requester. The pointer selects another core's per-core registers, or the shared global registers, at the same offset.

Requests arrive on a simple single-cycle bus that carries a requester ID. Every request receives a response flag exactly one cycle later. Read data comes with that flag, and writes always answer with zero data. The per-core and global register files are small stub memories, each a plain storage array. Only the pointer register and a read-only identity register have fixed meanings.

Top module: `rwr_window_redirector`

## Requirements
- R1: Address bits 14:13 select the window (0 global, 1 core-local, 2 core-remote, 3 debug), and `rsp_valid` is high exactly in the cycle after each accepted request; writes respond with zero data.
- R2: In the core-local window, word offset `addr[12:3]` (0x000 to 0x038) reaches the requester's own per-core register, and each core has separate storage.
- R3: The pointer register at per-core offset 0x018 keeps core target in bits 13:8, thread index in bits 2:0 and block select in bits 25:24; all other bits read as zero, and it resets to zero.
- R4: In the core-remote window with block select 0 and core target below the core count, an access reaches that target core's register at the same offset.
- R5: In the core-remote window, block select 1, or block select 0 with core target 32, reaches the global register at the same offset.
- R6: In the core-remote window, block select 2 or 3, or a core target at or above the core count other than 32, reads zero and ignores writes.
- R7: The register at per-core offset 0x018 + 0x010 (0x028) is read-only and returns the cluster number in bits 15:8 and the core number in bits 7:0, both through the local window and for a remote target.
- R8: Each requester has its own pointer; a write by one requester never changes another's pointer, and a write to offset 0x018 through the core-remote window is ignored while a read there returns the target's pointer.
- R9: The debug window reads zero and ignores writes.
- R10: Offsets at or above 0x040 in any window read zero and ignore writes, without aliasing onto lower registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_id | input | 2 | Requesting core index |
| req_addr | input | 15 | Byte address inside the register space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and unmapped targets |

## Verification
The bench targets the decisions that steer an access. One case is core target 32, which must reach the global registers; a design that compared only against the core count would return zero. A pointer with block select 2 must not fall through to core storage, and the bench checks this by writing through it and then reading the core's register directly. A remote write to offset 0x018 must leave the target's pointer unchanged; a design without this guard would let one core redirect another. The out-of-range offset 0x040 must not alias onto word 0, which a design that truncates the word index would do. Each of these mistakes shows up at the ports as wrong read data.

// File: rtl/rwr_pkg.sv
package rwr_pkg;
  typedef enum logic [2:0] {K_ZERO, K_CORE, K_GLB, K_PTR, K_ID} kind_e;

  // pointer register fields (core target, thread index, block select)
  typedef struct packed {
    logic [1:0] blk;
    logic [5:0] core;
    logic [2:0] vp;
  } ptr_t;

  localparam logic [1:0] WIN_GLB   = 2'd0;
  localparam logic [1:0] WIN_LOCAL = 2'd1;
  localparam logic [1:0] WIN_REMOTE = 2'd2;
  localparam logic [1:0] BLK_LOCAL = 2'd0;
  localparam logic [1:0] BLK_GLB   = 2'd1;
  localparam logic [5:0] CORE_GLOBAL = 6'd32;
  localparam int PTR_WORD = 3;  // offset 0x018
  localparam int ID_WORD  = 5;  // offset 0x028
endpackage

// File: rtl/rwr_decode.sv
module rwr_decode
  import rwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NREGS     = 8,
  localparam int CID_W    = $clog2(NUM_CORES),
  localparam int RI_W     = $clog2(NREGS)
) (
  input  logic [1:0]       win,
  input  logic [9:0]       word,
  input  logic [CID_W-1:0] req_id,
  input  ptr_t             sel,
  output kind_e            kind,
  output logic [CID_W-1:0] core,
  output logic [RI_W-1:0]  widx,
  output logic             wr_ok
);
  logic in_range;
  logic to_glb;
  logic to_core;

  assign in_range = (word < 10'(NREGS));
  assign widx     = word[RI_W-1:0];
  assign to_glb   = (sel.blk == BLK_GLB) ||
                    (sel.blk == BLK_LOCAL && sel.core == CORE_GLOBAL);
  assign to_core  = (sel.blk == BLK_LOCAL) && (sel.core < 6'(NUM_CORES));

  always_comb begin
    kind = K_ZERO;
    core = req_id;
    if (in_range) begin
      unique case (win)
        WIN_GLB: kind = K_GLB;
        WIN_LOCAL: begin
          if (word == 10'(ID_WORD))       kind = K_ID;
          else if (word == 10'(PTR_WORD)) kind = K_PTR;
          else                            kind = K_CORE;
        end
        WIN_REMOTE: begin
          if (to_glb) kind = K_GLB;
          else if (to_core) begin
            core = sel.core[CID_W-1:0];
            if (word == 10'(ID_WORD))       kind = K_ID;
            else if (word == 10'(PTR_WORD)) kind = K_PTR;
            else                            kind = K_CORE;
          end
        end
        default: kind = K_ZERO;
      endcase
    end
  end

  assign wr_ok = (kind == K_CORE) || (kind == K_GLB) ||
                 (kind == K_PTR && win == WIN_LOCAL);
endmodule

// File: rtl/rwr_ptr_bank.sv
module rwr_ptr_bank
  import rwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CID_W    = $clog2(NUM_CORES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [CID_W-1:0]              widx,
  input  ptr_t                          wval,
  input  logic [CID_W-1:0]              ra_idx,
  output ptr_t                          ra,
  input  logic [CID_W-1:0]              rb_idx,
  output ptr_t                          rb,
  output logic [NUM_CORES-1:0][$bits(ptr_t)-1:0] ptr_all
);
  ptr_t ptr_q [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)                         ptr_q[g] <= '0;
      else if (we && widx == CID_W'(g)) ptr_q[g] <= wval;
    end
    assign ptr_all[g] = ptr_q[g];
  end

  assign ra = ptr_q[ra_idx];
  assign rb = ptr_q[rb_idx];
endmodule

// File: rtl/rwr_stub_ram.sv
module rwr_stub_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rwr_window_redirector.sv
module rwr_window_redirector
  import rwr_pkg::*;
#(
  parameter int NUM_CORES        = 4,
  parameter int NREGS            = 8,
  parameter int DATA_W           = 32,
  parameter int ADDR_W           = 15,
  parameter logic [7:0] CLUSTER_ID = 8'h5A,
  localparam int CID_W           = $clog2(NUM_CORES),
  localparam int RI_W            = $clog2(NREGS),
  localparam int CDEPTH          = NUM_CORES * NREGS,
  localparam int CA_W            = $clog2(CDEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [CID_W-1:0]  req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  kind_e            kind;
  logic [CID_W-1:0] tgt_core;
  logic [RI_W-1:0]  widx;
  logic             wr_ok;
  ptr_t             sel_ptr;
  ptr_t             tgt_ptr;
  ptr_t             wr_ptr;
  logic [NUM_CORES-1:0][$bits(ptr_t)-1:0] ptr_all;
  logic [DATA_W-1:0] core_rdata, glb_rdata, aux_d, aux_q;
  kind_e            kind_q;
  logic             do_wr;
  logic [CA_W-1:0]  core_addr;

  rwr_decode #(.NUM_CORES(NUM_CORES), .NREGS(NREGS)) u_dec (
    .win(req_addr[ADDR_W-1:ADDR_W-2]), .word(req_addr[12:3]),
    .req_id(req_id), .sel(sel_ptr), .kind(kind), .core(tgt_core),
    .widx(widx), .wr_ok(wr_ok)
  );

  assign do_wr  = req_valid && req_we && wr_ok;
  assign wr_ptr = '{blk: req_wdata[25:24], core: req_wdata[13:8], vp: req_wdata[2:0]};

  rwr_ptr_bank #(.NUM_CORES(NUM_CORES)) u_ptr (
    .clk(clk), .rst(rst), .we(do_wr && kind == K_PTR), .widx(req_id),
    .wval(wr_ptr), .ra_idx(req_id), .ra(sel_ptr), .rb_idx(tgt_core),
    .rb(tgt_ptr), .ptr_all(ptr_all)
  );

  assign core_addr = CA_W'(tgt_core) * CA_W'(NREGS) + CA_W'(widx);

  rwr_stub_ram #(.DEPTH(CDEPTH), .DATA_W(DATA_W)) u_core_ram (
    .clk(clk), .we(do_wr && kind == K_CORE), .addr(core_addr),
    .wdata(req_wdata), .rdata(core_rdata)
  );

  rwr_stub_ram #(.DEPTH(NREGS), .DATA_W(DATA_W)) u_glb_ram (
    .clk(clk), .we(do_wr && kind == K_GLB), .addr(widx),
    .wdata(req_wdata), .rdata(glb_rdata)
  );

  always_comb begin
    aux_d = '0;
    if (kind == K_PTR)
      aux_d = DATA_W'({tgt_ptr.blk, 10'b0, tgt_ptr.core, 5'b0, tgt_ptr.vp});
    else if (kind == K_ID)
      aux_d = DATA_W'({CLUSTER_ID, 8'(tgt_core)});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      kind_q    <= K_ZERO;
      aux_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      kind_q    <= (req_valid && !req_we) ? kind : K_ZERO;
      aux_q     <= aux_d;
    end
  end

  always_comb begin
    unique case (kind_q)
      K_CORE:       rsp_rdata = core_rdata;
      K_GLB:        rsp_rdata = glb_rdata;
      K_PTR, K_ID:  rsp_rdata = aux_q;
      default:      rsp_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{req_addr[2:0], req_wdata[DATA_W-1:26], req_wdata[23:14], req_wdata[7:3], ptr_all};
endmodule

module rwr_redirect_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 15,
  parameter int PTR_W     = 11,
  localparam int CID_W    = $clog2(NUM_CORES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_we,
  input logic [CID_W-1:0]  req_id,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NUM_CORES-1:0][PTR_W-1:0] ptr_all
);
  logic [1:0] win;
  logic [1:0] own_blk;
  assign win     = req_addr[ADDR_W-1:ADDR_W-2];
  assign own_blk = ptr_all[req_id][PTR_W-1:PTR_W-2];

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_write_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we) |=> (rsp_rdata == '0));
  p_debug_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && win == 2'd3) |=> (rsp_rdata == '0));
  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && win == 2'd2 && own_blk[1]) |=> (rsp_rdata == '0));
  p_range_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && req_addr[12:6] != '0) |=> (rsp_rdata == '0));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_iso
    p_ptr_isolation_r8: assert property (@(posedge clk) disable iff (rst)
      !(req_valid && req_we && req_id == CID_W'(g) && win == 2'd1 &&
        req_addr[12:3] == 10'd3) |=> $stable(ptr_all[g]));
  end
endmodule

bind rwr_window_redirector rwr_redirect_chk #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_id(req_id), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .ptr_all(ptr_all)
);

// File: tb/rwr_window_redirector_tb.sv
module rwr_window_redirector_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CLUSTER = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_id = '0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwr_window_redirector #(.CLUSTER_ID(CLUSTER)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int id, input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_id = 2'(id); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic bus_read(input int id, input logic [14:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_id = 2'(id); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    if (rsp_valid !== 1'b1) begin
      n_checks++; n_fails++;
      $display("FAIL R1 rsp_valid: actual=%b expected=1", rsp_valid);
    end
  endtask

  function automatic logic [31:0] ptr_val(input int blk, input int core, input int vp);
    return (32'(blk) << 24) | (32'(core) << 8) | 32'(vp);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 rsp_valid idle after reset", {31'b0, rsp_valid}, 32'd0);
    bus_read(0, 15'h2018, d);
    check("R3 pointer reset value", d, 32'd0);
    @(negedge clk);
    check("R1 rsp_valid drops after one cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_local();
    logic [31:0] d;
    for (int c = 0; c < 4; c++) bus_write(c, 15'h2000, 32'hC0DE_0000 + 32'(c));
    for (int c = 0; c < 4; c++) begin
      bus_read(c, 15'h2000, d);
      check("R2 per-core local word 0", d, 32'hC0DE_0000 + 32'(c));
    end
    bus_write(2, 15'h2038, 32'h7777_0002);
    bus_read(2, 15'h2038, d);
    check("R2 local last word", d, 32'h7777_0002);
  endtask

  task automatic t_ptr_fields();
    logic [31:0] d;
    bus_write(1, 15'h2018, 32'hFFFF_FFFF);
    bus_read(1, 15'h2018, d);
    check("R3 pointer field mask", d, 32'h0300_3F07);
    bus_write(1, 15'h2018, 32'h0);
  endtask

  task automatic t_remote();
    logic [31:0] d;
    bus_write(0, 15'h2018, ptr_val(0, 2, 1));
    bus_read(0, 15'h4000, d);
    check("R4 remote read of core 2 word 0", d, 32'hC0DE_0002);
    bus_write(0, 15'h4008, 32'hABCD_1234);
    bus_read(2, 15'h2008, d);
    check("R4 remote write lands on core 2", d, 32'hABCD_1234);
  endtask

  task automatic t_global();
    logic [31:0] d;
    bus_write(3, 15'h0010, 32'h6100_0001);
    bus_read(3, 15'h0010, d);
    check("R1 global window direct", d, 32'h6100_0001);
    bus_write(0, 15'h2018, ptr_val(1, 0, 0));
    bus_read(0, 15'h4010, d);
    check("R5 block select global", d, 32'h6100_0001);
    bus_write(0, 15'h2018, ptr_val(0, 32, 0));
    bus_read(0, 15'h4010, d);
    check("R5 core 32 selects global", d, 32'h6100_0001);
    bus_write(0, 15'h4010, 32'h6100_0002);
    bus_read(1, 15'h0010, d);
    check("R5 remote write reaches global", d, 32'h6100_0002);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    bus_write(0, 15'h2018, ptr_val(2, 2, 0));
    bus_read(0, 15'h4000, d);
    check("R6 block select 2 reads zero", d, 32'd0);
    bus_write(0, 15'h4000, 32'hDEAD_BEEF);
    bus_write(0, 15'h2018, ptr_val(3, 2, 0));
    bus_read(0, 15'h4000, d);
    check("R6 block select 3 reads zero", d, 32'd0);
    bus_write(0, 15'h2018, ptr_val(0, 5, 0));
    bus_read(0, 15'h4000, d);
    check("R6 core beyond count reads zero", d, 32'd0);
    bus_write(0, 15'h4000, 32'hDEAD_BEEF);
    bus_read(2, 15'h2000, d);
    check("R6 ignored writes leave core 2", d, 32'hC0DE_0002);
    bus_read(0, 15'h2000, d);
    check("R6 ignored writes leave core 0", d, 32'hC0DE_0000);
  endtask

  task automatic t_id();
    logic [31:0] d;
    bus_read(3, 15'h2028, d);
    check("R7 local ID", d, {16'b0, CLUSTER, 8'd3});
    bus_write(3, 15'h2028, 32'hFFFF_FFFF);
    bus_read(3, 15'h2028, d);
    check("R7 ID ignores writes", d, {16'b0, CLUSTER, 8'd3});
    bus_write(0, 15'h2018, ptr_val(0, 1, 0));
    bus_read(0, 15'h4028, d);
    check("R7 remote ID of core 1", d, {16'b0, CLUSTER, 8'd1});
  endtask

  task automatic t_isolation();
    logic [31:0] d;
    bus_write(1, 15'h2018, ptr_val(0, 3, 2));
    bus_write(2, 15'h2018, ptr_val(1, 0, 5));
    bus_read(1, 15'h2018, d);
    check("R8 other requester write isolated", d, ptr_val(0, 3, 2));
    bus_write(0, 15'h2018, ptr_val(0, 1, 0));
    bus_write(0, 15'h4018, ptr_val(2, 9, 7));
    bus_read(1, 15'h2018, d);
    check("R8 remote pointer write ignored", d, ptr_val(0, 3, 2));
    bus_read(0, 15'h4018, d);
    check("R8 remote pointer read", d, ptr_val(0, 3, 2));
  endtask

  task automatic t_debug();
    logic [31:0] d;
    bus_write(0, 15'h6000, 32'h1234_5678);
    bus_read(0, 15'h6000, d);
    check("R9 debug reads zero", d, 32'd0);
    bus_read(0, 15'h2000, d);
    check("R9 debug write left local", d, 32'hC0DE_0000);
    bus_read(0, 15'h0000, d);
    check("R9 debug write left global", d, 32'd0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    bus_write(1, 15'h2040, 32'h5555_AAAA);
    bus_read(1, 15'h2040, d);
    check("R10 out-of-range reads zero", d, 32'd0);
    bus_read(1, 15'h2000, d);
    check("R10 no alias onto word 0", d, 32'hC0DE_0001);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    // prime global word 0 so the debug test has a known value
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    bus_write(0, 15'h0000, 32'd0);
    t_local();
    t_ptr_fields();
    t_remote();
    t_global();
    t_unimpl();
    t_id();
    t_isolation();
    t_debug();
    t_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule